// File: doc/BRIEF.md
# Capture/Reload Timer-Counter

A 16-bit up-counter with a companion capture/reload register and an 8-bit control register, all reached through a small byte-wide register port. The counter advances on an internal tick strobe or on falling edges of an external count pin. In capture mode, a falling edge on a trigger pin latches the running count into the companion register. In reload mode, the count is refilled from the companion register on wrap-around and, if enabled, on a trigger edge.

The block can also serve as a baud-rate generator. When either serial-clock select bit is set, every wrap-around reloads the count regardless of mode. The overflow flag stays quiet, trigger edges are ignored, and the one-cycle overflow pulse is forwarded on the receive and/or transmit baud output. Two sticky flags drive a level interrupt request. The register port and the pins are plain control signals with no handshake, because there is no data stream at the block's edge.

Top module: `crt_timer`

## Requirements
- R1: After reset, the control register, count and reload register read 0, and `irq_o`, `ovf_pulse_o`, `rx_baud_o` and `tx_baud_o` are 0.
- R2: Register map (default widths): address 0 is control, 1/2 are count low/high byte, 3/4 are reload low/high byte. Other addresses read 0. Control bits, from bit 7 down to 0: overflow flag, external flag, rx-clock select, tx-clock select, external enable, run, count-source select, capture select.
- R3: A step from 0xFFFF sets the overflow flag, unless rx- or tx-clock select is 1. The flag stays set until software writes it 0.
- R4: With capture select 1, external enable 1 and both clock selects 0, a trigger falling edge copies the count into the reload register, and the count is unchanged.
- R5: With capture select 0, a step from 0xFFFF loads the count from the reload register. A trigger falling edge also does so while external enable is 1. With capture select 1 and no clock select, the count wraps to 0.
- R6: Trigger edges have no effect (no capture, no reload, no external flag) when external enable is 0 or either clock select is 1.
- R7: The count only steps while the run bit is 1.
- R8: With count-source select 0, the count steps once per cycle in which `tick_i` is 1. With it at 1, the count steps once per falling edge of `cnt_pin_i`, and `tick_i` is ignored. Both pins pass through a two-flop synchronizer.
- R9: If either clock select is 1, a wrap-around reloads the count even with capture select 1. `ovf_pulse_o` is high for the one cycle after each wrap-around. `rx_baud_o` and `tx_baud_o` forward that pulse when their select bit is 1.
- R10: A trigger edge that causes a capture or reload sets the external flag, which stays set until software clears it. `irq_o` is the OR of the two flags.
- R11: A software write to a count or reload byte wins over a hardware step, reload or capture in the same cycle. A hardware flag set wins over a software clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Internal tick strobe |
| cnt_pin_i | input | 1 | External count pin (asynchronous) |
| trig_pin_i | input | 1 | Capture/reload trigger pin (asynchronous) |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational on addr_i) |
| irq_o | output | 1 | Interrupt request |
| ovf_pulse_o | output | 1 | One-cycle pulse after each wrap-around |
| rx_baud_o | output | 1 | Receive baud pulse |
| tx_baud_o | output | 1 | Transmit baud pulse |

## Verification
The hardest states to reach from the ports are same-cycle collisions. Examples are a count byte write landing on the same edge as a tick, or a control write that clears the overflow flag on the exact edge where the count wraps. The bench reaches them by raising `tick_i` and the write strobe on the same falling edge, so that both take effect at the one rising edge that follows. Trigger and count-pin edges are held for several cycles so that they cross the synchronizer at a known point before results are read.

// File: rtl/crt_pkg.sv
package crt_pkg;
  // control register, bit 7 first
  typedef struct packed {
    logic tf;       // overflow flag
    logic exf;      // external flag
    logic rx_sel;   // rx clock select
    logic tx_sel;   // tx clock select
    logic ext_en;   // external trigger enable
    logic run;      // run
    logic cnt_sel;  // 1: count pin edges, 0: ticks
    logic cap_sel;  // 1: capture, 0: reload
  } ctrl_t;
endpackage

// File: rtl/crt_fall_sync.sv
module crt_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/crt_ctrl_reg.sv
module crt_ctrl_reg
  import crt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       set_tf_i,
  input  logic       set_exf_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = ctrl_t'(wdata_i);
    if (set_tf_i) ctrl_d.tf = 1'b1;    // hardware set beats software clear
    if (set_exf_i) ctrl_d.exf = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/crt_core.sv
module crt_core #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  localparam int LANES = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inc_en_i,
  input  logic              auto_rld_i,
  input  logic              trig_ev_i,
  input  logic [LANES-1:0]  cnt_wr_i,
  input  logic [LANES-1:0]  rld_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;

  assign ovf_o = inc_en_i & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    if (|cnt_wr_i) begin
      for (int l = 0; l < LANES; l++)
        if (cnt_wr_i[l]) cnt_d[l*DATA_W +: DATA_W] = wdata_i;
    end else if (ovf_o) begin
      cnt_d = auto_rld_i ? rld_q : '0;
    end else if (trig_ev_i && auto_rld_i) begin
      cnt_d = rld_q;
    end else if (inc_en_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    rld_d = rld_q;
    if (|rld_wr_i) begin
      for (int l = 0; l < LANES; l++)
        if (rld_wr_i[l]) rld_d[l*DATA_W +: DATA_W] = wdata_i;
    end else if (trig_ev_i && !auto_rld_i) begin
      rld_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
    end
  end

  assign count_o  = cnt_q;
  assign reload_o = rld_q;
endmodule

// File: rtl/crt_timer.sv
module crt_timer
  import crt_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2,
  localparam int LANES   = CNT_W / DATA_W,
  localparam int ADDR_W  = $clog2(2 * LANES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              cnt_pin_i,
  input  logic              trig_pin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              ovf_pulse_o,
  output logic              rx_baud_o,
  output logic              tx_baud_o
);
  localparam int CNT_BASE = 1;
  localparam int RLD_BASE = 1 + LANES;

  ctrl_t            ctrl;
  logic [1:0]       pin_vec, fall_vec;
  logic             cnt_fall, trig_fall;
  logic             baud, auto_rld, inc_en, trig_ev, ovf, ovf_q;
  logic             ctrl_wr;
  logic [LANES-1:0] cnt_wr, rld_wr;
  logic [CNT_W-1:0] count, reload;

  assign pin_vec = {trig_pin_i, cnt_pin_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    crt_fall_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_vec[g]), .fall_o(fall_vec[g])
    );
  end
  assign cnt_fall  = fall_vec[0];
  assign trig_fall = fall_vec[1];

  // write decode
  assign ctrl_wr = we_i && (addr_i == ADDR_W'(0));
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign cnt_wr[l] = we_i && (addr_i == ADDR_W'(CNT_BASE + l));
    assign rld_wr[l] = we_i && (addr_i == ADDR_W'(RLD_BASE + l));
  end

  // event qualification
  assign baud     = ctrl.rx_sel | ctrl.tx_sel;
  assign auto_rld = baud | ~ctrl.cap_sel;
  assign inc_en   = ctrl.run & (ctrl.cnt_sel ? cnt_fall : tick_i);
  assign trig_ev  = trig_fall & ctrl.ext_en & ~baud;

  crt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_i(ctrl_wr), .wdata_i(wdata_i[7:0]),
    .set_tf_i(ovf & ~baud), .set_exf_i(trig_ev),
    .ctrl_o(ctrl)
  );

  crt_core #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .inc_en_i(inc_en), .auto_rld_i(auto_rld), .trig_ev_i(trig_ev),
    .cnt_wr_i(cnt_wr), .rld_wr_i(rld_wr), .wdata_i(wdata_i),
    .count_o(count), .reload_o(reload), .ovf_o(ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf;
  end

  assign ovf_pulse_o = ovf_q;
  assign rx_baud_o   = ovf_q & ctrl.rx_sel;
  assign tx_baud_o   = ovf_q & ctrl.tx_sel;
  assign irq_o       = ctrl.tf | ctrl.exf;

  // read mux
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(0)) rdata_o = DATA_W'(ctrl);
    for (int l = 0; l < LANES; l++) begin
      if (addr_i == ADDR_W'(CNT_BASE + l)) rdata_o = count[l*DATA_W +: DATA_W];
      if (addr_i == ADDR_W'(RLD_BASE + l)) rdata_o = reload[l*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ovf,
  input logic             baud,
  input logic             auto_rld,
  input logic             trig_ev,
  input logic             trig_fall,
  input logic             ext_en,
  input logic             run,
  input logic             ctrl_wr,
  input logic             cnt_wr_any,
  input logic             rld_wr_any,
  input logic             tf,
  input logic             exf,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             ovf_pulse_o,
  input logic             rx_baud_o,
  input logic             tx_baud_o
);
  p_tf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !baud |=> tf);
  p_no_tf_baud_r3: assert property (@(posedge clk) disable iff (!rst_n)
    baud |=> !$rose(tf));
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_ev && !auto_rld && !rld_wr_any |=> reload == $past(count));
  p_reload_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && auto_rld && !cnt_wr_any |=> count == $past(reload));
  p_trig_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fall && !ext_en |=> !$rose(exf));
  p_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr_any && !trig_ev |=> $stable(count));
  p_baud_fwd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_baud_o || tx_baud_o) |-> ovf_pulse_o);
  p_pulse_after_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf_pulse_o);
endmodule

bind crt_timer crt_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ovf(ovf), .baud(baud), .auto_rld(auto_rld),
  .trig_ev(trig_ev), .trig_fall(trig_fall), .ext_en(ctrl.ext_en), .run(ctrl.run),
  .ctrl_wr(ctrl_wr), .cnt_wr_any(|cnt_wr), .rld_wr_any(|rld_wr),
  .tf(ctrl.tf), .exf(ctrl.exf), .count(count), .reload(reload),
  .ovf_pulse_o(ovf_pulse_o), .rx_baud_o(rx_baud_o), .tx_baud_o(tx_baud_o)
);

// File: tb/crt_timer_tb_top.sv
`timescale 1ns/1ps
module crt_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, cnt_pin_i = 1'b0, trig_pin_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, ovf_pulse_o, rx_baud_o, tx_baud_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  crt_timer dut_i (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk); we_i = 1'b0;
  endtask

  task automatic wr16(logic [2:0] base, logic [15:0] v);
    wr(base, v[7:0]); wr(base + 3'd1, v[15:8]);
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic rd16(logic [2:0] base, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(base, lo); rd(base + 3'd1, hi); v = {hi, lo};
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0; #1;
  endtask

  task automatic trig_edge();
    @(negedge clk); trig_pin_i = 1'b1;
    repeat (4) @(negedge clk);
    trig_pin_i = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [15:0] v;
    rd(3'd0, d); chk("R1 ctrl", d, 8'h00);
    rd16(3'd1, v); chk("R1 count", v, 16'h0000);
    rd16(3'd3, v); chk("R1 reload", v, 16'h0000);
    chk("R1 irq/pulses", {irq_o, ovf_pulse_o, rx_baud_o, tx_baud_o}, 4'b0);
    rd(3'd7, d); chk("R2 unused addr", d, 8'h00);
  endtask

  task automatic t_run();
    logic [15:0] v;
    wr16(3'd1, 16'h0010);
    ticks(5); rd16(3'd1, v); chk("R7 stopped", v, 16'h0010);
    wr(3'd0, 8'h04);
    ticks(7); rd16(3'd1, v); chk("R8 tick count", v, 16'h0017);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] d; logic [15:0] v;
    wr16(3'd3, 16'h1234); wr16(3'd1, 16'hFFFE); wr(3'd0, 8'h05);
    ticks(2);
    rd16(3'd1, v); chk("R5 capture-mode wrap to 0", v, 16'h0000);
    rd(3'd0, d); chk("R3 tf set", d, 8'h85);
    chk("R10 irq", irq_o, 1'b1);
    ticks(3);
    rd(3'd0, d); chk("R3 tf sticky", d, 8'h85);
    wr(3'd0, 8'h05);
    rd(3'd0, d); chk("R3 tf cleared", d, 8'h05);
    chk("R10 irq low", irq_o, 1'b0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_autoreload();
    logic [7:0] d; logic [15:0] v;
    wr16(3'd3, 16'hABCD); wr16(3'd1, 16'hFFFF); wr(3'd0, 8'h04);
    ticks(1);
    chk("R9 ovf pulse", ovf_pulse_o, 1'b1);
    chk("R9 no baud", {rx_baud_o, tx_baud_o}, 2'b00);
    rd16(3'd1, v); chk("R5 reload on ovf", v, 16'hABCD);
    rd(3'd0, d); chk("R3 tf reload mode", d, 8'h84);
    chk("R9 pulse one cycle", ovf_pulse_o, 1'b0);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_trig_reload();
    logic [7:0] d; logic [15:0] v;
    wr16(3'd3, 16'h7777); wr16(3'd1, 16'h0005); wr(3'd0, 8'h08);
    trig_edge();
    rd16(3'd1, v); chk("R5 trigger reload", v, 16'h7777);
    rd(3'd0, d); chk("R10 exf set", d, 8'h48);
    chk("R10 irq exf", irq_o, 1'b1);
    wr(3'd0, 8'h00);
    chk("R10 exf cleared", irq_o, 1'b0);
  endtask

  task automatic t_capture();
    logic [7:0] d; logic [15:0] v;
    wr16(3'd3, 16'h0000); wr16(3'd1, 16'h4242); wr(3'd0, 8'h09);
    trig_edge();
    rd16(3'd3, v); chk("R4 captured", v, 16'h4242);
    rd16(3'd1, v); chk("R4 count kept", v, 16'h4242);
    rd(3'd0, d); chk("R10 exf on capture", d, 8'h49);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] d; logic [15:0] v;
    wr16(3'd3, 16'h1111); wr16(3'd1, 16'h2222); wr(3'd0, 8'h01);
    trig_edge();
    rd16(3'd3, v); chk("R6 no capture ext_en=0", v, 16'h1111);
    rd(3'd0, d); chk("R6 no exf ext_en=0", d, 8'h01);
    wr(3'd0, 8'h29);
    trig_edge();
    rd16(3'd3, v); chk("R6 no capture baud", v, 16'h1111);
    rd16(3'd1, v); chk("R6 count kept baud", v, 16'h2222);
    rd(3'd0, d); chk("R6 no exf baud", d, 8'h29);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_counter();
    logic [15:0] v;
    wr16(3'd1, 16'h0000); wr(3'd0, 8'h06);
    @(negedge clk); tick_i = 1'b1; cnt_pin_i = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      cnt_pin_i = 1'b0; repeat (4) @(negedge clk);
      cnt_pin_i = 1'b1; repeat (4) @(negedge clk);
    end
    tick_i = 1'b0;
    rd16(3'd1, v); chk("R8 pin edges", v, 16'h0003);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_baud();
    logic [7:0] d; logic [15:0] v;
    wr16(3'd3, 16'h0100); wr16(3'd1, 16'hFFFF); wr(3'd0, 8'h25);
    ticks(1);
    chk("R9 rx baud", {rx_baud_o, tx_baud_o, ovf_pulse_o}, 3'b101);
    rd16(3'd1, v); chk("R9 forced reload", v, 16'h0100);
    rd(3'd0, d); chk("R3 no tf in baud", d, 8'h25);
    wr(3'd0, 8'h15); wr16(3'd1, 16'hFFFF);
    ticks(1);
    chk("R9 tx baud", {rx_baud_o, tx_baud_o, ovf_pulse_o}, 3'b011);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d; logic [15:0] v;
    wr16(3'd1, 16'h0010); wr(3'd0, 8'h04);
    @(negedge clk); tick_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h80; we_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; we_i = 1'b0;
    rd16(3'd1, v); chk("R11 write beats step", v, 16'h0080);
    wr16(3'd1, 16'hFFFF);
    @(negedge clk); tick_i = 1'b1; addr_i = 3'd0; wdata_i = 8'h04; we_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; we_i = 1'b0;
    rd(3'd0, d); chk("R11 set beats clear", d, 8'h84);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_run();
    t_overflow();
    t_autoreload();
    t_trig_reload();
    t_capture();
    t_ignored();
    t_counter();
    t_baud();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule